// File: doc/BRIEF.md
# Single-Channel DMA Engine with Selectable Peripheral Handshake

This block is one DMA channel. It moves packets of 1, 2 or 4 bytes between a memory-side address and a device-side address over a simple bus-master port. Each packet is one read beat followed by one write beat. The transfer direction, the per-side address stepping, the packet size and the pacing mode are all captured from plain configuration inputs when a start pulse arrives. The channel then runs on its own until it reaches a completion state.

Pacing has two modes. In hardware mode, a peripheral drives one slice of a wide request/terminate bus that many peripherals share. A 7-bit selector picks which slice belongs to this channel, and the channel returns a one-cycle done pulse on that same slice of a done bus. In firmware mode, the handshake bus is ignored and packets stream back to back.

The channel asks an external arbiter for the bus before each packet. If the lock option is set, it holds the arbiter from the first grant until the transfer ends. The bus port uses valid/ready. Once `bus_valid` is raised, the beat stays posted with the same address, direction and write data until the target raises `bus_ready`. The beat completes in the cycle where both signals are high. For a read beat, `bus_rdata` is taken in that cycle. A target applies back-pressure simply by holding `bus_ready` low.

Top module: `dma_chan_flow`

## Requirements
- R1: With `cfg_dir`=1, each packet reads from the memory address and then writes to the device address. With `cfg_dir`=0, each packet reads from the device address and then writes to the memory address. The written data equals the data read in the same packet, and `bus_write` is 1 only on write beats.
- R2: The size code selects the packet size: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. With `cfg_mem_inc`=1, the memory address steps by that size after every packet. The transfer ends with `st_done`=1 when the stepped address is at or above `cfg_mem_end`.
- R3: With `cfg_dev_inc`=1, the device address steps by the packet size after every packet. With `cfg_dev_inc`=0, it stays at `cfg_dev_addr`.
- R4: With `cfg_mem_inc`=0, the channel never sets `st_done`. It keeps moving packets until a terminate or an abort ends it.
- R5: `cfg_sel` picks bit index `cfg_sel` of `hs_req`, `hs_term` and `hs_done`. Other slices have no effect, and `hs_done` only ever pulses on the selected bit.
- R6: In hardware mode (`cfg_fc_off`=0), no packet starts without the selected request. One packet is moved per request. `hs_done` pulses for one cycle in the cycle after the write beat completes, and the request is not sampled during that pulse cycle.
- R7: In hardware mode, the selected terminate ends an active transfer with `st_terminated`=1. If a beat is in flight, the transfer ends after that beat completes.
- R8: With `cfg_fc_off`=1, `hs_req` and `hs_term` are ignored, packets run back to back, and `hs_done` stays 0.
- R9: With `cfg_lock`=1, `arb_lock` rises in the cycle after the first grant and stays high until the transfer ends, and packets proceed without any further grant. With `cfg_lock`=0, every packet waits for its own grant.
- R10: `abort_req` stops an active transfer after the beat in flight completes, sets `st_aborted` and clears `st_active`. An abort while idle has no effect.
- R11: While `bus_valid`=1 and `bus_ready`=0, the next cycle keeps `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` unchanged.
- R12: If the final write beat completes in the same cycle as an abort or terminate, the result is `st_done`=1 and the other two status bits stay 0. At most one status bit is ever set.
- R13: After reset, `st_active`, all three status bits, `bus_valid`, `arb_req`, `arb_lock` and `hs_done` are 0. A start pulse clears the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only while idle |
| abort_req | input | 1 | Software abort pulse |
| cfg_dir | input | 1 | 1: memory to device, 0: device to memory |
| cfg_mem_inc | input | 1 | Step the memory address per packet |
| cfg_dev_inc | input | 1 | Step the device address per packet |
| cfg_size | input | 2 | Packet size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| cfg_fc_off | input | 1 | 1: firmware pacing, handshake bus ignored |
| cfg_lock | input | 1 | Hold the arbiter from first grant to completion |
| cfg_sel | input | SELW (7) | Handshake slice index |
| cfg_mem_start | input | AW | Memory start address |
| cfg_mem_end | input | AW | Memory end address |
| cfg_dev_addr | input | AW | Device start address |
| hs_req | input | NDEV | Shared request bus, one bit per peripheral |
| hs_term | input | NDEV | Shared terminate bus |
| hs_done | output | NDEV | Per-packet done pulse on the selected slice |
| arb_req | output | 1 | Bus request to the external arbiter |
| arb_lock | output | 1 | Arbitration lock held until completion |
| arb_gnt | input | 1 | Grant from the arbiter |
| bus_valid | output | 1 | Beat posted |
| bus_write | output | 1 | 1: write beat, 0: read beat |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Target accepts the beat |
| bus_rdata | input | DW | Read data, valid when a read beat completes |
| st_active | output | 1 | Transfer in progress |
| st_done | output | 1 | Ended by reaching the memory end |
| st_aborted | output | 1 | Ended by software abort |
| st_terminated | output | 1 | Ended by hardware terminate |

## Verification
Two things can land in the same cycle: completion of the final write beat, which ends the transfer as done, and an abort request that arrives while that beat is posted. The bench stalls the last write with `bus_ready` low. It then raises `bus_ready` and `abort_req` together, so both are seen at one clock edge, and it expects done with no aborted flag. A companion case sends the same abort on a non-final write and expects that beat to complete before the channel reports aborted, which shows the priority rule and not a missed abort.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ARB,
    S_RD,
    S_WR
  } chan_st_e;

  typedef struct packed {
    logic       dir;
    logic       mem_inc;
    logic       dev_inc;
    logic       fc_off;
    logic       lock;
    logic [1:0] size;
  } chan_ctl_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr,
  output logic [AW:0]   nxt
);
  assign nxt = {1'b0, addr} + (AW+1)'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= nxt[AW-1:0];
  end
endmodule

// File: rtl/dma_hs_sel.sv
module dma_hs_sel #(
  parameter int NDEV = 128,
  parameter int SELW = 7
) (
  input  logic [SELW-1:0] sel,
  input  logic [NDEV-1:0] req_bus,
  input  logic [NDEV-1:0] term_bus,
  input  logic            pulse,
  output logic            req,
  output logic            term,
  output logic [NDEV-1:0] done_bus
);
  logic [NDEV-1:0] hit;

  for (genvar i = 0; i < NDEV; i++) begin : g_slice
    assign hit[i]      = (sel == SELW'(i));
    assign done_bus[i] = pulse & hit[i];
  end

  assign req  = |(req_bus & hit);
  assign term = |(term_bus & hit);
endmodule

// File: rtl/dma_chan_flow.sv
module dma_chan_flow
  import dma_chan_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NDEV = 128,
  parameter int SELW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            abort_req,
  input  logic            cfg_dir,
  input  logic            cfg_mem_inc,
  input  logic            cfg_dev_inc,
  input  logic [1:0]      cfg_size,
  input  logic            cfg_fc_off,
  input  logic            cfg_lock,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_mem_start,
  input  logic [AW-1:0]   cfg_mem_end,
  input  logic [AW-1:0]   cfg_dev_addr,
  input  logic [NDEV-1:0] hs_req,
  input  logic [NDEV-1:0] hs_term,
  output logic [NDEV-1:0] hs_done,
  output logic            arb_req,
  output logic            arb_lock,
  input  logic            arb_gnt,
  output logic            bus_valid,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_size,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ready,
  input  logic [DW-1:0]   bus_rdata,
  output logic            st_active,
  output logic            st_done,
  output logic            st_aborted,
  output logic            st_terminated
);
  chan_st_e        st_q, st_d;
  chan_ctl_t       c_q;
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   end_q;
  logic [DW-1:0]   data_q;
  logic            lock_q, ab_pend, tm_pend, done_q;
  logic            s_done, s_ab, s_tm;
  logic [AW-1:0]   mem_addr, dev_addr;
  logic [AW:0]     mem_nxt, dev_nxt;
  logic [2:0]      step;
  logic            hw, req_s, term_s, term_now, ab_any, tm_any;
  logic            rd_fire, wr_fire, last, start;
  logic            fin_done, fin_ab, fin_tm, fin_any;

  assign start    = (st_q == S_IDLE) && go;
  assign step     = size_bytes(c_q.size);
  assign hw       = !c_q.fc_off;
  assign rd_fire  = (st_q == S_RD) && bus_ready;
  assign wr_fire  = (st_q == S_WR) && bus_ready;
  assign term_now = hw && term_s;
  assign ab_any   = abort_req || ab_pend;
  assign tm_any   = term_now || tm_pend;
  assign last     = c_q.mem_inc && (mem_nxt >= {1'b0, end_q});
  assign fin_any  = fin_done || fin_ab || fin_tm;

  dma_addr_ctr #(.AW(AW)) i_mem_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(cfg_mem_start),
    .adv(wr_fire && c_q.mem_inc), .step(step), .addr(mem_addr), .nxt(mem_nxt)
  );

  dma_addr_ctr #(.AW(AW)) i_dev_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(cfg_dev_addr),
    .adv(wr_fire && c_q.dev_inc), .step(step), .addr(dev_addr), .nxt(dev_nxt)
  );

  dma_hs_sel #(.NDEV(NDEV), .SELW(SELW)) i_hs_sel (
    .sel(sel_q), .req_bus(hs_req), .term_bus(hs_term), .pulse(done_q),
    .req(req_s), .term(term_s), .done_bus(hs_done)
  );

  // Sequencing: wait for pacing, win arbitration, read beat, write beat.
  always_comb begin
    st_d     = st_q;
    fin_done = 1'b0;
    fin_ab   = 1'b0;
    fin_tm   = 1'b0;
    case (st_q)
      S_IDLE: if (go) st_d = S_WAIT;
      S_WAIT: begin
        if (ab_any)      fin_ab = 1'b1;
        else if (tm_any) fin_tm = 1'b1;
        else if (!hw || (req_s && !done_q)) st_d = lock_q ? S_RD : S_ARB;
      end
      S_ARB: begin
        if (ab_any)       fin_ab = 1'b1;
        else if (tm_any)  fin_tm = 1'b1;
        else if (arb_gnt) st_d = S_RD;
      end
      S_RD: if (bus_ready) begin
        if (ab_any)      fin_ab = 1'b1;
        else if (tm_any) fin_tm = 1'b1;
        else             st_d = S_WR;
      end
      S_WR: if (bus_ready) begin
        if (last)        fin_done = 1'b1;
        else if (ab_any) fin_ab = 1'b1;
        else if (tm_any) fin_tm = 1'b1;
        else             st_d = S_WAIT;
      end
      default: st_d = S_IDLE;
    endcase
    if (fin_any) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      c_q     <= '0;
      sel_q   <= '0;
      end_q   <= '0;
      data_q  <= '0;
      lock_q  <= 1'b0;
      ab_pend <= 1'b0;
      tm_pend <= 1'b0;
      done_q  <= 1'b0;
      s_done  <= 1'b0;
      s_ab    <= 1'b0;
      s_tm    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= wr_fire && hw;
      if (st_q == S_IDLE) begin
        ab_pend <= 1'b0;
        tm_pend <= 1'b0;
        if (go) begin
          c_q    <= '{dir: cfg_dir, mem_inc: cfg_mem_inc, dev_inc: cfg_dev_inc,
                      fc_off: cfg_fc_off, lock: cfg_lock, size: cfg_size};
          sel_q  <= cfg_sel;
          end_q  <= cfg_mem_end;
          s_done <= 1'b0;
          s_ab   <= 1'b0;
          s_tm   <= 1'b0;
        end
      end else begin
        if (abort_req) ab_pend <= 1'b1;
        if (term_now)  tm_pend <= 1'b1;
      end
      if (rd_fire) data_q <= bus_rdata;
      if (fin_any) lock_q <= 1'b0;
      else if ((st_q == S_ARB) && arb_gnt && c_q.lock) lock_q <= 1'b1;
      if (fin_done) s_done <= 1'b1;
      if (fin_ab)   s_ab   <= 1'b1;
      if (fin_tm)   s_tm   <= 1'b1;
    end
  end

  assign bus_valid     = (st_q == S_RD) || (st_q == S_WR);
  assign bus_write     = (st_q == S_WR);
  assign bus_addr      = ((st_q == S_RD) == c_q.dir) ? mem_addr : dev_addr;
  assign bus_size      = c_q.size;
  assign bus_wdata     = data_q;
  assign arb_req       = (st_q == S_ARB) || bus_valid || lock_q;
  assign arb_lock      = lock_q;
  assign st_active     = (st_q != S_IDLE);
  assign st_done       = s_done;
  assign st_aborted    = s_ab;
  assign st_terminated = s_tm;

  // R11: a stalled beat keeps its contents
  a_r11_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                && $stable(bus_write) && $stable(bus_wdata));

  // R12: never more than one completion status
  a_r12_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_done, st_aborted, st_terminated}));

  // R9: lock only while a transfer is live
  a_r9_lock_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lock |-> st_active);

  // R4: done only reachable with memory stepping enabled
  a_r4_done_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> c_q.mem_inc);

  // R5: done pulse on at most one slice
  a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_done));

  // R8: firmware pacing never pulses the handshake
  a_r8_fw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (|hs_done) |-> !c_q.fc_off);
endmodule

// File: tb/test_dma_chan_flow.sv
module test_dma_chan_flow;
  localparam int CLK_P = 10;
  localparam int AW = 32, DW = 32, NDEV = 128, SELW = 7;

  logic clk = 0, rst_n = 0;
  logic go = 0, abort_req = 0;
  logic cfg_dir = 0, cfg_mem_inc = 0, cfg_dev_inc = 0, cfg_fc_off = 0, cfg_lock = 0;
  logic [1:0] cfg_size = 0;
  logic [SELW-1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_mem_start = 0, cfg_mem_end = 0, cfg_dev_addr = 0;
  logic [NDEV-1:0] hs_req = 0, hs_term = 0, hs_done;
  logic arb_req, arb_lock, arb_gnt, gnt_en = 1;
  logic bus_valid, bus_write, bus_ready, rdy = 1;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic st_active, st_done, st_aborted, st_terminated;

  int n_chk = 0, n_err = 0;
  int rn = 0, wn = 0, dn = 0, last_done_idx = -1;
  logic [31:0] rd_log [64];
  logic [31:0] wa_log [64];
  logic [31:0] wd_log [64];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    pat = {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  assign bus_rdata = pat(bus_addr);
  assign bus_ready = rdy;
  assign arb_gnt   = arb_req && gnt_en;

  dma_chan_flow #(.AW(AW), .DW(DW), .NDEV(NDEV), .SELW(SELW)) i_dma_chan_flow (
    .clk(clk), .rst_n(rst_n), .go(go), .abort_req(abort_req),
    .cfg_dir(cfg_dir), .cfg_mem_inc(cfg_mem_inc), .cfg_dev_inc(cfg_dev_inc),
    .cfg_size(cfg_size), .cfg_fc_off(cfg_fc_off), .cfg_lock(cfg_lock),
    .cfg_sel(cfg_sel), .cfg_mem_start(cfg_mem_start), .cfg_mem_end(cfg_mem_end),
    .cfg_dev_addr(cfg_dev_addr), .hs_req(hs_req), .hs_term(hs_term),
    .hs_done(hs_done), .arb_req(arb_req), .arb_lock(arb_lock), .arb_gnt(arb_gnt),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .st_active(st_active), .st_done(st_done),
    .st_aborted(st_aborted), .st_terminated(st_terminated)
  );

  // bus / handshake monitor
  always @(posedge clk) begin
    if (rst_n && bus_valid && bus_ready) begin
      if (bus_write) begin
        wa_log[wn % 64] <= bus_addr;
        wd_log[wn % 64] <= bus_wdata;
        wn <= wn + 1;
      end else begin
        rd_log[rn % 64] <= bus_addr;
        rn <= rn + 1;
      end
    end
    if (rst_n && (|hs_done)) begin
      dn <= dn + 1;
      for (int i = 0; i < NDEV; i++) if (hs_done[i]) last_done_idx <= i;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic dir, input logic minc, input logic dinc, input logic [1:0] sz,
                       input logic fcoff, input logic lk, input logic [6:0] sel,
                       input logic [31:0] ms, input logic [31:0] me, input logic [31:0] da);
    @(negedge clk);
    cfg_dir = dir; cfg_mem_inc = minc; cfg_dev_inc = dinc; cfg_size = sz;
    cfg_fc_off = fcoff; cfg_lock = lk; cfg_sel = sel;
    cfg_mem_start = ms; cfg_mem_end = me; cfg_dev_addr = da;
    go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic wait_idle(input int max);
    for (int i = 0; i < max && st_active; i++) @(negedge clk);
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_req = 1;
    @(negedge clk); abort_req = 0;
  endtask

  task automatic t_reset();
    chk(!st_active && !st_done && !st_aborted && !st_terminated, "R13 status", {st_active, st_done, st_aborted, st_terminated}, 0);
    chk(!bus_valid && !arb_req && !arb_lock, "R13 bus/arb idle", {bus_valid, arb_req, arb_lock}, 0);
    chk(hs_done == 0, "R13 hs_done", hs_done[31:0], 0);
  endtask

  task automatic t_mem_to_dev();
    int w0 = wn, r0 = rn;
    setup(1, 1, 0, 2'd2, 1, 0, 0, 32'h100, 32'h110, 32'h40);
    wait_idle(200);
    chk(wn - w0 == 4, "R2 packet count", wn - w0, 4);
    chk(st_done && !st_active, "R2 done status", {st_done, st_active}, 2'b10);
    for (int k = 0; k < 4; k++) begin
      chk(rd_log[r0 + k] == 32'h100 + 4*k, "R1 R2 read from memory", rd_log[r0 + k], 32'h100 + 4*k);
      chk(wa_log[w0 + k] == 32'h40, "R3 fixed device addr", wa_log[w0 + k], 32'h40);
      chk(wd_log[w0 + k] == pat(32'h100 + 4*k), "R1 data carried", wd_log[w0 + k], pat(32'h100 + 4*k));
    end
  endtask

  task automatic t_dev_to_mem();
    int w0 = wn, r0 = rn;
    setup(0, 1, 1, 2'd1, 1, 0, 0, 32'h200, 32'h204, 32'h80);
    wait_idle(200);
    chk(wn - w0 == 2, "R2 2-byte count", wn - w0, 2);
    for (int k = 0; k < 2; k++) begin
      chk(rd_log[r0 + k] == 32'h80 + 2*k, "R1 R3 read from device stepped", rd_log[r0 + k], 32'h80 + 2*k);
      chk(wa_log[w0 + k] == 32'h200 + 2*k, "R1 R2 write to memory", wa_log[w0 + k], 32'h200 + 2*k);
    end
    chk(st_done, "R2 done", st_done, 1);
  endtask

  task automatic t_hw_flow();
    int w0 = wn, r0 = rn, d0 = dn;
    bit seen = 0;
    setup(1, 1, 0, 2'd2, 0, 0, 7'd5, 32'h300, 32'h400, 32'h50);
    hs_req[3] = 1;
    repeat (10) @(negedge clk);
    chk(wn == w0 && rn == r0, "R5 R6 no packet without own request", wn - w0, 0);
    hs_req[3] = 0;
    hs_req[5] = 1;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (|hs_done) begin
        seen = 1;
        chk(hs_done == (NDEV'(1) << 5), "R5 done on selected slice", hs_done[31:0], 32'h20);
        hs_req[5] = 0;
      end
    end
    chk(seen, "R6 done pulse", seen, 1);
    repeat (10) @(negedge clk);
    chk(wn - w0 == 1, "R6 one packet per request", wn - w0, 1);
    chk(rd_log[r0] == 32'h300, "R6 packet address", rd_log[r0], 32'h300);
    chk(dn - d0 == 1 && last_done_idx == 5, "R5 single pulse index", last_done_idx, 5);
    @(negedge clk); hs_term[3] = 1; @(negedge clk); hs_term[3] = 0;
    repeat (3) @(negedge clk);
    chk(st_active, "R5 other terminate ignored", st_active, 1);
    @(negedge clk); hs_term[5] = 1; @(negedge clk); hs_term[5] = 0;
    wait_idle(20);
    chk(st_terminated && !st_active && !st_done, "R7 terminated", {st_terminated, st_active, st_done}, 3'b100);
  endtask

  task automatic t_fw_forever();
    int w0 = wn, r0 = rn, d0 = dn;
    setup(0, 0, 1, 2'd0, 1, 0, 7'd0, 32'h500, 32'h501, 32'h10);
    repeat (30) @(negedge clk);
    hs_req[0] = 1; hs_term[0] = 1;
    @(negedge clk);
    hs_req[0] = 0; hs_term[0] = 0;
    repeat (5) @(negedge clk);
    chk(st_active && !st_terminated, "R8 terminate ignored", {st_active, st_terminated}, 2'b10);
    chk(wn - w0 >= 5, "R4 R8 runs on without requests", wn - w0, 5);
    chk(!st_done, "R4 never done", st_done, 0);
    chk(wa_log[w0 + 2] == 32'h500, "R4 memory addr fixed", wa_log[w0 + 2], 32'h500);
    chk(rd_log[r0 + 1] == 32'h11, "R2 R3 1-byte step", rd_log[r0 + 1], 32'h11);
    chk(dn == d0, "R8 no done pulses", dn - d0, 0);
    pulse_abort();
    wait_idle(20);
    chk(st_aborted && !st_active, "R10 aborted", {st_aborted, st_active}, 2'b10);
    pulse_abort();
    repeat (3) @(negedge clk);
    chk(!st_active && !bus_valid && st_aborted, "R10 idle abort no effect", {st_active, bus_valid}, 0);
  endtask

  task automatic t_lock();
    int w0 = wn;
    bit up = 0;
    setup(1, 1, 0, 2'd2, 1, 1, 7'd0, 32'h600, 32'h610, 32'h60);
    for (int i = 0; i < 30 && !up; i++) begin
      @(negedge clk);
      if (arb_lock) begin up = 1; gnt_en = 0; end
    end
    chk(up, "R9 lock raised", up, 1);
    wait_idle(100);
    chk(st_done && wn - w0 == 4, "R9 locked completes without grant", wn - w0, 4);
    chk(!arb_lock && !arb_req, "R9 lock released", arb_lock, 0);
    gnt_en = 1;
    w0 = wn;
    setup(1, 1, 0, 2'd2, 1, 0, 7'd0, 32'h600, 32'h610, 32'h60);
    for (int i = 0; i < 30 && wn == w0; i++) @(negedge clk);
    gnt_en = 0;
    repeat (20) @(negedge clk);
    chk(st_active && wn - w0 < 4 && !arb_lock, "R9 unlocked stalls without grant", wn - w0, 1);
    pulse_abort();
    wait_idle(20);
    gnt_en = 1;
    chk(st_aborted && !arb_req, "R10 abort while waiting grant", st_aborted, 1);
  endtask

  // abort raised in the cycle the write with index 'which' is accepted
  task automatic t_collide(input int which, input logic [31:0] me, input bit exp_done);
    int w0 = wn;
    bit hit = 0;
    setup(1, 1, 0, 2'd2, 1, 0, 7'd0, 32'h700, me, 32'h70);
    for (int i = 0; i < 60 && !hit; i++) begin
      if (bus_valid && bus_write && (wn - w0 == which)) begin
        rdy = 0;
        repeat (3) @(negedge clk);
        chk(bus_valid && bus_write, "R11 write held under back-pressure", bus_valid, 1);
        rdy = 1; abort_req = 1;
        @(negedge clk);
        abort_req = 0;
        hit = 1;
      end else @(negedge clk);
    end
    rdy = 1;
    wait_idle(50);
    chk(wn - w0 == which + 1, "R10 R12 beat in flight completes", wn - w0, which + 1);
    if (exp_done)
      chk(st_done && !st_aborted, "R12 done wins over abort", {st_done, st_aborted}, 2'b10);
    else
      chk(st_aborted && !st_done, "R10 abort after beat", {st_done, st_aborted}, 2'b01);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mem_to_dev();
    t_dev_to_mem();
    t_hw_flow();
    t_fw_forever();
    t_lock();
    t_collide(1, 32'h708, 1);
    t_collide(0, 32'h710, 0);
  endtask

  initial begin
    bit timeout = 0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule